// File: doc/BRIEF.md
# PRBS Analyzer Lock Monitor

This block watches a serial bit stream that arrives one bit per strobe and judges it against a locally produced pseudo-random reference of period 2^15-1. It produces two results. The first is an out-of-lock alarm. The second is a saturating error tally that counts mismatches seen while the analyzer holds lock.

While it is out of lock, the block seeds its reference from the line. Each received bit is shifted into the generator, so after fifteen clean bits the prediction follows the sender. A run of 24 consecutive correct predictions declares lock. Once locked, the reference runs freely and each mismatch counts as a bit error. The locked stream is cut into consecutive windows of 1000 bits that do not overlap. If 30 errors collect inside one window, the analyzer drops back to acquisition.

The analyzer enable gates the whole function. With the enable low, the alarm reads 0 and the lock state is held in acquisition.

Top module: `prbs_lock_mon`

## Requirements
- R1: While reset is held, and directly after it, the alarm is 1 when the enable is 1 and the error count is 0. The reference register resets to all ones.
- R2: The predicted bit is the XOR of reference bits 14 and 13, which gives the polynomial x^15 + x^14 + 1. A sender whose generator also starts from all ones therefore matches from its first bit.
- R3: While acquiring, every valid received bit is shifted into the reference. The 24th consecutive matching bit declares lock, and the alarm reads 0 from the clock edge that takes that bit.
- R4: While locked, the reference advances on its own prediction regardless of the line. A received bit that differs from the prediction is an error, and fewer than 30 errors in a window keep lock.
- R5: The first window starts when lock is declared, and each window spans 1000 valid locked bits. At every window end the error tally of the window returns to zero. The 30th error inside one window drops lock at the edge that takes it.
- R6: The error count rises by one per locked error, including the error that drops lock. It does not change while out of lock.
- R7: The error count stops at all ones instead of wrapping.
- R8: With the enable low, the alarm is 0 and received bits are ignored. The state returns to acquisition with the reference at all ones, and the error count keeps its value. After the enable rises, the alarm is 1 until lock is taken again.
- R9: A cycle with the bit strobe low changes neither the state nor the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Analyzer enable |
| bitValid | input | 1 | Strobe marking a valid received bit |
| bitIn | input | 1 | Received data bit |
| outOfLock | output | 1 | Out-of-lock alarm, 0 while disabled |
| errCount | output | CNT_W (16) | Saturating count of locked bit errors |

## Verification
A fault in the reference taps or in the seeding path makes lock arrive late or not at all. That shows on the alarm within the first 24 to 40 bits of an aligned stream. A wrong window length or a wrong tally reset shows only at a window boundary: errors split across two windows either drop lock or fail to. The bench therefore places error bursts on both sides of a boundary and checks the alarm after every bit. A wrong count freeze or saturation shows on the count output at the first error after the state in question.

// File: rtl/prbs_mon_pkg.sv
package prbs_mon_pkg;

  typedef enum logic {
    ST_ACQ  = 1'b0,
    ST_LOCK = 1'b1
  } monState_t;

  typedef struct packed {
    logic refReset;
    logic seedLoad;
    logic trackErr;
    logic winClear;
    logic runClear;
  } monStrobe_t;

endpackage

// File: rtl/prbs_mon_datapath.sv
module prbs_mon_datapath
  import prbs_mon_pkg::*;
#(
  parameter int REF_LEN   = 15,
  parameter int TAP_HI    = 15,
  parameter int TAP_LO    = 14,
  parameter int LOCK_RUN  = 24,
  parameter int WIN_LEN   = 1000,
  parameter int ERR_LIMIT = 30,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitValid,
  input  logic             bitIn,
  input  monStrobe_t       strobe,
  output logic             runDone,
  output logic             winFail,
  output logic [CNT_W-1:0] errCount
);

  localparam int RUN_W   = $clog2(LOCK_RUN + 1);
  localparam int WIN_W   = $clog2(WIN_LEN + 1);
  localparam int TALLY_W = $clog2(ERR_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [REF_LEN-1:0] refReg;
  logic               expBit;
  logic               mismatch;
  logic               feedBit;
  logic [RUN_W-1:0]   runCnt;
  logic [WIN_W-1:0]   winIdx;
  logic [TALLY_W-1:0] winErr;
  logic               winEnd;
  logic               lockedErr;

  // Reference generator: prediction taps, feedback choice
  generate
    if (TAP_LO == 0) begin : g_singleTap
      assign expBit = refReg[TAP_HI-1];
    end else begin : g_twoTap
      assign expBit = refReg[TAP_HI-1] ^ refReg[TAP_LO-1];
    end
  endgenerate

  assign mismatch  = bitIn ^ expBit;
  assign feedBit   = strobe.seedLoad ? bitIn : expBit;
  assign lockedErr = bitValid & strobe.trackErr & mismatch;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.refReset) begin
      refReg <= '1;
    end else if (bitValid) begin
      refReg <= {refReg[REF_LEN-2:0], feedBit};
    end
  end

  // Acquisition run of consecutive correct predictions
  assign runDone = bitValid & strobe.seedLoad & ~mismatch &
                   (runCnt == RUN_W'(LOCK_RUN - 1));

  always_ff @(posedge clk) begin
    if (!rstN || strobe.runClear || runDone) begin
      runCnt <= '0;
    end else if (bitValid && strobe.seedLoad) begin
      runCnt <= mismatch ? '0 : runCnt + 1'b1;
    end
  end

  // Observation window and its error tally
  assign winEnd  = (winIdx == WIN_W'(WIN_LEN - 1));
  assign winFail = lockedErr & (winErr == TALLY_W'(ERR_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rstN || strobe.winClear) begin
      winIdx <= '0;
      winErr <= '0;
    end else if (bitValid && strobe.trackErr) begin
      if (winEnd) begin
        winIdx <= '0;
        winErr <= '0;
      end else begin
        winIdx <= winIdx + 1'b1;
        winErr <= winErr + TALLY_W'(mismatch);
      end
    end
  end

  // Saturating error count
  always_ff @(posedge clk) begin
    if (!rstN) begin
      errCount <= '0;
    end else if (lockedErr && (errCount != CNT_MAX)) begin
      errCount <= errCount + 1'b1;
    end
  end

  assert_count_frozen_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(bitValid && strobe.trackErr) |=> $stable(errCount));

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (errCount != CNT_MAX) |=>
      (errCount == $past(errCount) || errCount == $past(errCount) + 1'b1));

  assert_count_saturate_R7: assert property (@(posedge clk) disable iff (!rstN)
    (errCount == CNT_MAX) |=> (errCount == CNT_MAX));

  assert_window_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.trackErr |-> (winErr < TALLY_W'(ERR_LIMIT) && winIdx < WIN_W'(WIN_LEN)));

  assert_seed_follows_line_R3: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && strobe.seedLoad && !strobe.refReset) |=> (refReg[0] == $past(bitIn)));

endmodule

// File: rtl/prbs_mon_ctrl.sv
module prbs_mon_ctrl
  import prbs_mon_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       bitValid,
  input  logic       runDone,
  input  logic       winFail,
  output monStrobe_t strobe,
  output logic       outOfLock
);

  monState_t state;
  monState_t nextState;

  always_comb begin
    strobe    = '0;
    nextState = state;
    if (!enable) begin
      strobe.refReset = 1'b1;
      strobe.runClear = 1'b1;
      strobe.winClear = 1'b1;
      nextState       = ST_ACQ;
    end else begin
      unique case (state)
        ST_ACQ: begin
          strobe.seedLoad = 1'b1;
          if (runDone) begin
            strobe.winClear = 1'b1;
            nextState       = ST_LOCK;
          end
        end
        ST_LOCK: begin
          strobe.trackErr = 1'b1;
          if (winFail) begin
            strobe.runClear = 1'b1;
            nextState       = ST_ACQ;
          end
        end
        default: nextState = ST_ACQ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_ACQ;
    end else begin
      state <= nextState;
    end
  end

  assign outOfLock = enable & (state == ST_ACQ);

  assert_disable_to_acq_R8: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (state == ST_ACQ));

  assert_lock_entry_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_LOCK) |-> $past(runDone && enable));

  assert_lock_exit_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(state == ST_LOCK) |-> $past(winFail || !enable));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !bitValid) |=> $stable(state));

endmodule

// File: rtl/prbs_lock_mon.sv
module prbs_lock_mon
  import prbs_mon_pkg::*;
#(
  parameter int REF_LEN   = 15,
  parameter int TAP_HI    = 15,
  parameter int TAP_LO    = 14,
  parameter int LOCK_RUN  = 24,
  parameter int WIN_LEN   = 1000,
  parameter int ERR_LIMIT = 30,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             bitValid,
  input  logic             bitIn,
  output logic             outOfLock,
  output logic [CNT_W-1:0] errCount
);

  monStrobe_t strobe;
  logic       runDone;
  logic       winFail;

  prbs_mon_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .bitValid  (bitValid),
    .runDone   (runDone),
    .winFail   (winFail),
    .strobe    (strobe),
    .outOfLock (outOfLock)
  );

  prbs_mon_datapath #(
    .REF_LEN   (REF_LEN),
    .TAP_HI    (TAP_HI),
    .TAP_LO    (TAP_LO),
    .LOCK_RUN  (LOCK_RUN),
    .WIN_LEN   (WIN_LEN),
    .ERR_LIMIT (ERR_LIMIT),
    .CNT_W     (CNT_W)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .bitValid (bitValid),
    .bitIn    (bitIn),
    .strobe   (strobe),
    .runDone  (runDone),
    .winFail  (winFail),
    .errCount (errCount)
  );

endmodule

// File: tb/prbs_lock_mon_tb.sv
module prbs_lock_mon_tb;

  localparam int CW   = 8;
  localparam int MAXC = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          enable = 1'b0;
  logic          bitValid = 1'b0;
  logic          bitIn = 1'b0;
  logic          outOfLock;
  logic [CW-1:0] errCount;

  always #5 clk = ~clk;

  prbs_lock_mon #(.CNT_W(CW)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .bitValid(bitValid),
    .bitIn(bitIn), .outOfLock(outOfLock), .errCount(errCount)
  );

  int    nChecks = 0;
  int    nErrs = 0;
  string tag = "R1";

  // Requirement-level expectation state
  logic [14:0] hist;
  logic [14:0] gen;
  bit          mLocked;
  int          mRun, mWin, mTally, mErrs;

  task automatic check(input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrs++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic checkOuts();
    check("alarm", int'(outOfLock), int'(enable && !mLocked));
    check("count", int'(errCount), mErrs);
  endtask

  task automatic genNext(output bit b);
    b = gen[14] ^ gen[13];
    gen = {gen[13:0], b};
  endtask

  task automatic modelStep(input bit b);
    bit pred, err;
    if (!enable) return;
    pred = hist[14] ^ hist[13];
    err = b ^ pred;
    if (!mLocked) begin
      hist = {hist[13:0], b};
      mRun = err ? 0 : mRun + 1;
      if (mRun == 24) begin
        mLocked = 1; mRun = 0; mWin = 0; mTally = 0;
      end
    end else begin
      hist = {hist[13:0], pred};
      if (err) begin
        if (mErrs < MAXC) mErrs++;
        mTally++;
      end
      if (mTally == 30) begin
        mLocked = 0; mRun = 0;
      end else begin
        mWin++;
        if (mWin == 1000) begin mWin = 0; mTally = 0; end
      end
    end
  endtask

  task automatic sendBit(input bit b);
    bitValid = 1'b1;
    bitIn = b;
    modelStep(b);
    @(negedge clk);
    bitValid = 1'b0;
    checkOuts();
  endtask

  task automatic idle(input int n);
    bitValid = 1'b0;
    bitIn = ~bitIn;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      checkOuts();
    end
  endtask

  task automatic prbsBits(input int n);
    bit b;
    for (int k = 0; k < n; k++) begin
      genNext(b);
      sendBit(b);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nErrs++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    bit b;
    int used;
    hist = '1; gen = '1; mLocked = 0; mRun = 0; mWin = 0; mTally = 0; mErrs = 0;
    enable = 1'b1;

    // R1: reset state
    tag = "R1";
    repeat (3) @(negedge clk);
    checkOuts();
    rstN = 1'b1;
    @(negedge clk);
    checkOuts();

    // R2: aligned sender matches from its first bit
    tag = "R2";
    prbsBits(23);
    check("alarm before 24th bit", int'(outOfLock), 1);
    tag = "R3";
    prbsBits(1);
    check("lock on 24th bit", int'(outOfLock), 0);

    // R9: idle strobes change nothing
    tag = "R9";
    idle(5);

    // R4: 29 errors in one window keep lock, idle gaps inside
    tag = "R4";
    for (int i = 0; i < 1000; i++) begin
      genNext(b);
      sendBit(b ^ (i % 34 == 33));
      if (i % 97 == 50) begin tag = "R9"; idle(2); tag = "R4"; end
    end
    check("locked after 29 errors", int'(outOfLock), 0);
    check("count after 29 errors", int'(errCount), 29);

    // R5: 20 errors at the end of one window and 20 at the start of the next
    tag = "R5";
    for (int i = 0; i < 1000; i++) begin
      genNext(b);
      sendBit(b ^ (i >= 980));
    end
    for (int i = 0; i < 1000; i++) begin
      genNext(b);
      sendBit(b ^ (i < 20));
    end
    check("lock kept across boundary", int'(outOfLock), 0);
    check("count after split bursts", int'(errCount), 69);

    // R5: 30 errors in one window drop lock on the 30th
    used = 0;
    for (int i = 0; i < 100 && mLocked; i++) begin
      genNext(b);
      sendBit(b ^ (i % 2 == 0));
      used++;
    end
    check("bits until loss", used, 59);
    check("alarm after loss", int'(outOfLock), 1);
    tag = "R6";
    check("count includes 30th error", int'(errCount), 99);

    // R6: count frozen while out of lock
    for (int i = 0; i < 200; i++) sendBit(i % 2 == 0);
    check("count frozen out of lock", int'(errCount), 99);

    // R3: reacquire by seeding from the line
    tag = "R3";
    used = 0;
    for (int i = 0; i < 60 && !mLocked; i++) begin
      genNext(b);
      sendBit(b);
      used++;
    end
    check("reacquired", int'(outOfLock), 0);
    check("reacquire within seed plus run", int'(used <= 39), 1);

    // R8: enable low forces alarm off, ignores bits, keeps count
    tag = "R8";
    enable = 1'b0;
    mLocked = 0; hist = '1; mRun = 0;
    @(negedge clk);
    checkOuts();
    for (int i = 0; i < 20; i++) sendBit(i % 3 == 0);
    check("count held while disabled", int'(errCount), 99);
    enable = 1'b1;
    @(negedge clk);
    check("alarm back after enable", int'(outOfLock), 1);
    gen = '1;
    prbsBits(23);
    check("still acquiring after 23", int'(outOfLock), 1);
    prbsBits(1);
    check("relock from all-ones reference", int'(outOfLock), 0);

    // R7: saturation
    tag = "R7";
    for (int w = 0; w < 7; w++) begin
      for (int i = 0; i < 1000; i++) begin
        genNext(b);
        sendBit(b ^ (i % 34 == 33));
      end
    end
    check("count saturated", int'(errCount), MAXC);
    check("lock kept while saturating", int'(outOfLock), 0);

    summary();
    $finish;
  end

endmodule